// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the time of day as three chained fields: a half-second count, a minute count and an hour count. A single-cycle tick input, produced elsewhere from a reference clock, advances the half-second field. Carries ripple into minutes and hours, and the whole time wraps to 00:00 after 23:59:59.5. Software can write and read every field through a small register port.

Two interrupt outputs are provided. The interval interrupt pulses at a selectable period of 0.5 s, 1 s, 1 min, 1 h or 24 h. The alarm interrupt pulses when the time reached on a tick equals a programmed alarm setting, which has its own half-second, minute and hour fields. Both outputs are registered pulses, one cycle wide, that appear in the cycle after the tick that causes them.

Top module: `tod_alarm_top`

## Requirements
- R1: After reset, all three time fields and all three alarm fields read 0, the interval select reads 7 (interrupt disabled), and both interrupt outputs are low.
- R2: Each tick advances the half-second field by one. It counts 0..119 and goes from 119 to 0, and that wrap advances the minute field by one.
- R3: The minute field counts 0..59, and its wrap advances the hour field. The hour field counts 0..23 and goes from 23 to 0.
- R4: Register map for write and read: address 0 = half-second, 1 = minute, 2 = hour, 3 = alarm half-second, 4 = alarm minute, 5 = alarm hour, 6 = interval select (bits 2:0). A write is visible from the next cycle. rd_data shows the register at rd_addr one cycle after the address is presented.
- R5: A write to a time field (addresses 0..2) in the same cycle as a tick takes effect, and that tick is dropped: no field advances and no interrupt results.
- R6: A write of a value outside a field's range (half-second ≥120, minute ≥60, hour ≥24, for time and alarm fields alike) leaves the field unchanged.
- R7: Interval select codes and the tick on which irq_interval pulses: 0 = every tick; 1 = a tick that leaves the half-second field even; 2 = a tick that wraps the half-second field; 3 = a tick that wraps both half-second and minute; 4 = a tick that wraps all three fields.
- R8: Interval select codes 5, 6 and 7 keep irq_interval low.
- R9: irq_alarm pulses for one cycle, in the cycle after a tick, when the time reached by that tick equals all three alarm fields.
- R10: Register writes alone never raise either interrupt, even when a write makes the time equal the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_half | input | 1 | One-cycle half-second advance strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_interval | output | 1 | Periodic interval interrupt pulse |
| irq_alarm | output | 1 | Alarm match interrupt pulse |

## Verification
The table-driven part presets the time just before each carry boundary: mid-minute, an odd and an even half-second, the end of a minute, the end of an hour and the end of a day. It then applies one tick under every interval code. This separates the five periods from one another and from the disabled codes, and it shows whether the right carry reached the right field. Alarm vectors match on all three fields, on only two fields, and across the midnight wrap, so a compare that ignores a field is caught. Directed cases cover a write that collides with a tick, out-of-range writes, a write that lands on the alarm time, and a run of back-to-back ticks through a full rollover.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_HALF    = 3'd0,
    RA_MIN     = 3'd1,
    RA_HOUR    = 3'd2,
    RA_AL_HALF = 3'd3,
    RA_AL_MIN  = 3'd4,
    RA_AL_HOUR = 3'd5,
    RA_IVL     = 3'd6
  } reg_addr_e;

  typedef enum logic [2:0] {
    IV_HALF_SEC = 3'd0,
    IV_SEC      = 3'd1,
    IV_MINUTE   = 3'd2,
    IV_HOUR     = 3'd3,
    IV_DAY      = 3'd4,
    IV_OFF      = 3'd7
  } ivl_code_e;
endpackage

// File: rtl/tod_field.sv
module tod_field #(
  parameter int LIMIT = 60,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP_V = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign wrap = inc && (cnt_q >= TOP_V);

  always_comb begin
    cnt_nxt = cnt_q;
    if (ld)        cnt_nxt = ld_val;
    else if (wrap) cnt_nxt = '0;
    else if (inc)  cnt_nxt = cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  // R6: the field never leaves its legal range
  a_r6_field_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP_V);

  // R2 / R3: an advance from the top value lands on zero
  a_r2_field_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && cnt_q == TOP_V) |=> (cnt_q == '0));

  // R2 / R3: an advance below the top value adds exactly one
  a_r3_field_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && cnt_q < TOP_V) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/tod_interval.sv
module tod_interval (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic [2:0] sel,
  input  logic       half_nxt_lsb,
  input  logic       wrap_half,
  input  logic       wrap_min,
  input  logic       wrap_hour,
  output logic       irq
);
  import tod_pkg::*;

  logic hit;

  always_comb begin
    unique case (sel)
      IV_HALF_SEC: hit = 1'b1;
      IV_SEC:      hit = !half_nxt_lsb;
      IV_MINUTE:   hit = wrap_half;
      IV_HOUR:     hit = wrap_half && wrap_min;
      IV_DAY:      hit = wrap_half && wrap_min && wrap_hour;
      default:     hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= adv && hit;
  end

  // R8: codes above 4 keep the interval output quiet
  a_r8_code_off: assert property (@(posedge clk) disable iff (rst)
    (sel > 3'd4) |=> !irq);

  // R7: code 0 pulses on every effective advance
  a_r7_every_tick: assert property (@(posedge clk) disable iff (rst)
    (adv && sel == 3'd0) |=> irq);
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp #(
  parameter int HW = 7,
  parameter int MW = 6,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [HW-1:0] half_nxt,
  input  logic [MW-1:0] min_nxt,
  input  logic [RW-1:0] hour_nxt,
  input  logic [HW-1:0] al_half,
  input  logic [MW-1:0] al_min,
  input  logic [RW-1:0] al_hour,
  output logic          irq
);
  logic match;

  assign match = (half_nxt == al_half) && (min_nxt == al_min) && (hour_nxt == al_hour);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= adv && match;
  end

  // R9: the alarm output is a single-cycle pulse
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/tod_alarm_top.sv
module tod_alarm_top #(
  parameter int HALF_PER_MIN  = 120,
  parameter int MIN_PER_HOUR  = 60,
  parameter int HOUR_PER_DAY  = 24,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_half,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq_interval,
  output logic          irq_alarm
);
  import tod_pkg::*;

  localparam int HW = $clog2(HALF_PER_MIN);
  localparam int MW = $clog2(MIN_PER_HOUR);
  localparam int RW = $clog2(HOUR_PER_DAY);
  localparam logic [DW-1:0] LIM_H = DW'(HALF_PER_MIN);
  localparam logic [DW-1:0] LIM_M = DW'(MIN_PER_HOUR);
  localparam logic [DW-1:0] LIM_R = DW'(HOUR_PER_DAY);

  // write decode
  logic ok_h, ok_m, ok_r;
  logic cnt_wr, adv;
  logic ld_h, ld_m, ld_r;

  assign ok_h   = wr_data < LIM_H;
  assign ok_m   = wr_data < LIM_M;
  assign ok_r   = wr_data < LIM_R;
  assign cnt_wr = wr_en && (wr_addr == RA_HALF || wr_addr == RA_MIN || wr_addr == RA_HOUR);
  assign adv    = tick_half && !cnt_wr;
  assign ld_h   = wr_en && wr_addr == RA_HALF && ok_h;
  assign ld_m   = wr_en && wr_addr == RA_MIN  && ok_m;
  assign ld_r   = wr_en && wr_addr == RA_HOUR && ok_r;

  // time chain
  logic [HW-1:0] half_q, half_nxt;
  logic [MW-1:0] min_q,  min_nxt;
  logic [RW-1:0] hour_q, hour_nxt;
  logic wrap_h, wrap_m, wrap_r;
  logic inc_m, inc_r;

  assign inc_m = wrap_h;
  assign inc_r = wrap_m;

  tod_field #(.LIMIT(HALF_PER_MIN), .W(HW)) u_half (
    .clk(clk), .rst(rst), .inc(adv), .ld(ld_h), .ld_val(wr_data[HW-1:0]),
    .cnt(half_q), .cnt_nxt(half_nxt), .wrap(wrap_h));

  tod_field #(.LIMIT(MIN_PER_HOUR), .W(MW)) u_min (
    .clk(clk), .rst(rst), .inc(inc_m), .ld(ld_m), .ld_val(wr_data[MW-1:0]),
    .cnt(min_q), .cnt_nxt(min_nxt), .wrap(wrap_m));

  tod_field #(.LIMIT(HOUR_PER_DAY), .W(RW)) u_hour (
    .clk(clk), .rst(rst), .inc(inc_r), .ld(ld_r), .ld_val(wr_data[RW-1:0]),
    .cnt(hour_q), .cnt_nxt(hour_nxt), .wrap(wrap_r));

  // alarm and interval settings
  logic [HW-1:0] al_half_q;
  logic [MW-1:0] al_min_q;
  logic [RW-1:0] al_hour_q;
  logic [2:0]    ivl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_half_q <= '0;
      al_min_q  <= '0;
      al_hour_q <= '0;
      ivl_q     <= IV_OFF;
    end else if (wr_en) begin
      if (wr_addr == RA_AL_HALF && ok_h) al_half_q <= wr_data[HW-1:0];
      if (wr_addr == RA_AL_MIN  && ok_m) al_min_q  <= wr_data[MW-1:0];
      if (wr_addr == RA_AL_HOUR && ok_r) al_hour_q <= wr_data[RW-1:0];
      if (wr_addr == RA_IVL)             ivl_q     <= wr_data[2:0];
    end
  end

  tod_interval u_ivl (
    .clk(clk), .rst(rst), .adv(adv), .sel(ivl_q),
    .half_nxt_lsb(half_nxt[0]), .wrap_half(wrap_h), .wrap_min(wrap_m),
    .wrap_hour(wrap_r), .irq(irq_interval));

  tod_alarm_cmp #(.HW(HW), .MW(MW), .RW(RW)) u_alm (
    .clk(clk), .rst(rst), .adv(adv),
    .half_nxt(half_nxt), .min_nxt(min_nxt), .hour_nxt(hour_nxt),
    .al_half(al_half_q), .al_min(al_min_q), .al_hour(al_hour_q),
    .irq(irq_alarm));

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        RA_HALF:    rd_data <= DW'(half_q);
        RA_MIN:     rd_data <= DW'(min_q);
        RA_HOUR:    rd_data <= DW'(hour_q);
        RA_AL_HALF: rd_data <= DW'(al_half_q);
        RA_AL_MIN:  rd_data <= DW'(al_min_q);
        RA_AL_HOUR: rd_data <= DW'(al_hour_q);
        RA_IVL:     rd_data <= DW'(ivl_q);
        default:    rd_data <= '0;
      endcase
    end
  end

  // R10: without a tick neither interrupt can pulse
  a_r10_no_tick_quiet: assert property (@(posedge clk) disable iff (rst)
    !tick_half |=> (!irq_interval && !irq_alarm));

  // R5: a legal half-second write wins over a tick in the same cycle
  a_r5_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && wr_data < LIM_H) |=> (half_q == $past(wr_data[HW-1:0])));

  // R5: a colliding tick leaves minute and hour untouched
  a_r5_tick_dropped: assert property (@(posedge clk) disable iff (rst)
    (tick_half && wr_en && wr_addr == 3'd0) |=> ($stable(min_q) && $stable(hour_q)));
endmodule

// File: tb/sim_tod_alarm_top.sv
module sim_tod_alarm_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_half = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_interval, irq_alarm;

  always #2 clk = ~clk;  // 250 MHz

  tod_alarm_top u0 (
    .clk(clk), .rst(rst), .tick_half(tick_half), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_interval(irq_interval), .irq_alarm(irq_alarm));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [7:0] ph, pm, pr;   // preset time
    logic [2:0] sel;
    logic [7:0] ah, am, ar;   // alarm
    logic [7:0] eh, em, er;   // expected time after one tick
    logic       ei, ea;       // expected interrupts
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'd5,   8'd0,  8'd0,  3'd0, 8'd100, 8'd50, 8'd20, 8'd6,   8'd0,  8'd0,  1'b1, 1'b0},
    '{8'd6,   8'd0,  8'd0,  3'd1, 8'd100, 8'd50, 8'd20, 8'd7,   8'd0,  8'd0,  1'b0, 1'b0},
    '{8'd7,   8'd0,  8'd0,  3'd1, 8'd100, 8'd50, 8'd20, 8'd8,   8'd0,  8'd0,  1'b1, 1'b0},
    '{8'd119, 8'd10, 8'd3,  3'd2, 8'd100, 8'd50, 8'd20, 8'd0,   8'd11, 8'd3,  1'b1, 1'b0},
    '{8'd118, 8'd10, 8'd3,  3'd2, 8'd100, 8'd50, 8'd20, 8'd119, 8'd10, 8'd3,  1'b0, 1'b0},
    '{8'd119, 8'd59, 8'd3,  3'd3, 8'd100, 8'd50, 8'd20, 8'd0,   8'd0,  8'd4,  1'b1, 1'b0},
    '{8'd119, 8'd58, 8'd3,  3'd3, 8'd100, 8'd50, 8'd20, 8'd0,   8'd59, 8'd3,  1'b0, 1'b0},
    '{8'd119, 8'd59, 8'd23, 3'd4, 8'd100, 8'd50, 8'd20, 8'd0,   8'd0,  8'd0,  1'b1, 1'b0},
    '{8'd119, 8'd59, 8'd22, 3'd4, 8'd100, 8'd50, 8'd20, 8'd0,   8'd0,  8'd23, 1'b0, 1'b0},
    '{8'd10,  8'd20, 8'd5,  3'd5, 8'd11,  8'd20, 8'd5,  8'd11,  8'd20, 8'd5,  1'b0, 1'b1},
    '{8'd10,  8'd20, 8'd5,  3'd7, 8'd11,  8'd21, 8'd5,  8'd11,  8'd20, 8'd5,  1'b0, 1'b0},
    '{8'd119, 8'd59, 8'd23, 3'd6, 8'd0,   8'd0,  8'd0,  8'd0,   8'd0,  8'd0,  1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic tick(output int ii, output int ia);
    tick_half = 1'b1;
    @(negedge clk);
    ii = int'(irq_interval); ia = int'(irq_alarm);
    tick_half = 1'b0;
  endtask

  initial begin
    int v, ii, ia;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq_interval", int'(irq_interval), 0);
    chk("R1 irq_alarm", int'(irq_alarm), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 field reset", v, 0);
    end
    rd(3'd6, v); chk("R1 interval select reset", v, 7);

    // table: preset, one tick, compare (R2 R3 R4 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VEC[i].ph); wr(3'd1, VEC[i].pm); wr(3'd2, VEC[i].pr);
      wr(3'd3, VEC[i].ah); wr(3'd4, VEC[i].am); wr(3'd5, VEC[i].ar);
      wr(3'd6, 8'(VEC[i].sel));
      tick(ii, ia);
      chk("R7 R8 interval pulse", ii, int'(VEC[i].ei));
      chk("R9 alarm pulse", ia, int'(VEC[i].ea));
      rd(3'd0, v); chk("R2 half after tick", v, int'(VEC[i].eh));
      rd(3'd1, v); chk("R3 minute after tick", v, int'(VEC[i].em));
      rd(3'd2, v); chk("R3 hour after tick", v, int'(VEC[i].er));
    end

    // R5: counter write collides with a tick
    wr(3'd6, 8'd0); wr(3'd0, 8'd10); wr(3'd1, 8'd7);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd50; tick_half = 1'b1;
    @(negedge clk);
    ii = int'(irq_interval);
    wr_en = 1'b0; tick_half = 1'b0;
    chk("R5 no interrupt on dropped tick", ii, 0);
    rd(3'd0, v); chk("R5 write wins", v, 50);
    rd(3'd1, v); chk("R5 minute untouched", v, 7);

    // R6: out-of-range writes ignored
    wr(3'd0, 8'd120); rd(3'd0, v); chk("R6 half 120 ignored", v, 50);
    wr(3'd1, 8'd60);  rd(3'd1, v); chk("R6 minute 60 ignored", v, 7);
    wr(3'd2, 8'd24);  rd(3'd2, v); chk("R6 hour 24 ignored", v, 0);
    wr(3'd4, 8'd200); rd(3'd4, v); chk("R6 alarm minute ignored", v, 0);
    wr(3'd0, 8'd119); rd(3'd0, v); chk("R6 half 119 accepted", v, 119);

    // R10: a write that lands on the alarm time raises nothing
    wr(3'd3, 8'd40); wr(3'd4, 8'd7); wr(3'd5, 8'd0);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd40;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 alarm after write", int'(irq_alarm), 0);
    chk("R10 interval after write", int'(irq_interval), 0);
    @(negedge clk);
    chk("R10 alarm one cycle later", int'(irq_alarm), 0);

    // R2 R3: back-to-back ticks through a full rollover
    wr(3'd0, 8'd117); wr(3'd1, 8'd59); wr(3'd2, 8'd23); wr(3'd6, 8'd4);
    tick(ii, ia); chk("R7 day code quiet before wrap", ii, 0);
    tick(ii, ia);
    tick(ii, ia); chk("R7 day code at midnight", ii, 1);
    rd(3'd0, v); chk("R2 half rolled", v, 0);
    rd(3'd1, v); chk("R3 minute rolled", v, 0);
    rd(3'd2, v); chk("R3 hour rolled", v, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule